// File: doc/BRIEF.md
# Two-Stage Programmable Bit-Rate Generator

This block produces the timing strobes a serial transmitter and receiver need. It works on one clock. An optional fixed prescaler turns that clock into an enable strobe that fires once every eight cycles. A 16-bit sample divider counts those enabled cycles and emits `sample_tick` once every CD of them. An 8-bit bit-period divider groups BDIV+1 sample ticks into one bit time and marks the last of them with `baud_tick`. The resulting bit rate is selected_clock / (CD × (BDIV+1)).

Configuration arrives over a small write-only port with three addressed settings: the prescale select, CD and BDIV. Software picks the divisor values. Any accepted configuration write restarts every counter, so the first period after a change is always complete. A CD below 2 turns both strobes off.

Top module: `bitclk_gen`

## Requirements
- R1: While reset is high and afterwards, both strobes are low. Reset clears CD, BDIV and the prescale select to zero, so the strobes stay off until a CD of 2 or more is written.
- R2: With the prescale select clear, the first `sample_tick` comes in clock cycle CD−1 after the edge that accepts the last configuration write, where the cycle right after that edge is cycle 0. Later ones follow every CD cycles.
- R3: With the prescale select set (write address 0, bit 0 = 1), every sample interval is eight times longer. The first `sample_tick` comes in cycle 8×CD−1, and a sample tick only fires on a cycle where the prescaler strobe is active.
- R4: The first `baud_tick` comes in cycle P×CD×(BDIV+1)−1, and later ones follow every P×CD×(BDIV+1) cycles, where P is 8 with the prescale select set and 1 otherwise.
- R5: Every `baud_tick` falls on the same cycle as a `sample_tick`, namely the one that completes the (BDIV+1)-th sample. Exactly BDIV+1 sample ticks occur from one baud tick to the next.
- R6: A CD value of 0 or 1 keeps both strobes low.
- R7: Any accepted configuration write (address 0, 1 or 2) restarts all counters from zero, so timing is measured afresh from that write. No sample tick occurs in the cycle right after it.
- R8: Each strobe is one clock wide: `sample_tick` is never high in two consecutive cycles.
- R9: The write addresses are fixed: 0 selects the prescale bit (data bit 0), 1 selects CD (data bits 15:0) and 2 selects BDIV (data bits 7:0). A write to address 3 changes no setting and does not restart the counters.
- R10: The full field ranges work. CD = 65535 gives its first sample tick in cycle 65534, and BDIV = 255 groups 256 sample ticks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Setting select: 0 prescale, 1 CD, 2 BDIV, 3 none |
| wr_data | input | 16 | Write data |
| sample_tick | output | 1 | One-cycle strobe every CD selected-clock cycles |
| baud_tick | output | 1 | One-cycle strobe marking the last sample of each bit |

## Verification
A counter that has lost its phase, or one that never restarted after a write, moves the first strobe away from its computed cycle. That error is visible within one sample interval for `sample_tick` and within one bit period for `baud_tick`. A wrong bit-period count shows up as a wrong number of sample ticks between two baud ticks, so it is exposed by the second baud tick. A latched setting that has been corrupted, such as a write to address 3 that aliased onto CD, changes the spacing of the very next strobe.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

    localparam int DEF_CD_W    = 16;
    localparam int DEF_BD_W    = 8;
    localparam int DEF_PRE_DIV = 8;
    localparam int MIN_CD      = 2;

    typedef enum logic [1:0] {
        ADDR_MODE = 2'd0,
        ADDR_CD   = 2'd1,
        ADDR_BDIV = 2'd2,
        ADDR_RSVD = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic sample;
        logic baud;
    } tick_t;

endpackage

// File: rtl/bitclk_cfg.sv
module bitclk_cfg
    import bitclk_pkg::*;
#(
    parameter int CD_W = DEF_CD_W,
    parameter int BD_W = DEF_BD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [CD_W-1:0] wr_data,
    output logic            presc_sel,
    output logic [CD_W-1:0] cd,
    output logic [BD_W-1:0] bdiv,
    output logic            restart
);
    cfg_addr_e addr;
    assign addr    = cfg_addr_e'(wr_addr);
    assign restart = wr_en && (addr != ADDR_RSVD);

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_sel <= 1'b0;
            cd        <= '0;
            bdiv      <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_MODE: presc_sel <= wr_data[0];
                ADDR_CD:   cd        <= wr_data;
                ADDR_BDIV: bdiv      <= wr_data[BD_W-1:0];
                default:   ;
            endcase
        end
    end

    // R9: a write to the reserved address leaves every setting untouched
    assert_rsvd_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd3) |=> ($stable(cd) && $stable(bdiv) && $stable(presc_sel)));

endmodule

// File: rtl/bitclk_prescale.sv
module bitclk_prescale
    import bitclk_pkg::*;
#(
    parameter int PRE_DIV = DEF_PRE_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic presc_en,
    output logic strobe
);
    generate
        if (PRE_DIV > 1) begin : g_div
            localparam int PW = $clog2(PRE_DIV);
            localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
            logic [PW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || restart) cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else cnt <= cnt + 1'b1;
            end

            assign strobe = !presc_en || (cnt == LAST);

            // R3: with prescaling on, the strobe never fires on two consecutive cycles
            assert_presc_gap_R3: assert property (@(posedge clk) disable iff (rst)
                (presc_en && strobe && !restart) |=> (!strobe || !presc_en));
        end else begin : g_pass
            assign strobe = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/bitclk_divider.sv
module bitclk_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         step,
    input  logic         active,
    input  logic [W-1:0] last,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (step && active) cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    assign hit = step && active && (cnt == last);

    // R2: the count never passes its terminal value while running
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= last));

    // R8: a hit is a single-cycle strobe
    assert_single_hit_R8: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
    import bitclk_pkg::*;
#(
    parameter int CD_W    = DEF_CD_W,
    parameter int BD_W    = DEF_BD_W,
    parameter int PRE_DIV = DEF_PRE_DIV
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [CD_W-1:0] wr_data,
    output logic            sample_tick,
    output logic            baud_tick
);
    logic            presc_sel;
    logic [CD_W-1:0] cd;
    logic [BD_W-1:0] bdiv;
    logic            restart;
    logic            pre_strobe;
    logic            cd_ok;
    tick_t           ticks;

    bitclk_cfg #(.CD_W(CD_W), .BD_W(BD_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .presc_sel(presc_sel), .cd(cd), .bdiv(bdiv), .restart(restart)
    );

    bitclk_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst(rst), .restart(restart), .presc_en(presc_sel), .strobe(pre_strobe)
    );

    assign cd_ok = (cd >= CD_W'(MIN_CD));

    bitclk_divider #(.W(CD_W)) u_sample (
        .clk(clk), .rst(rst), .restart(restart), .step(pre_strobe),
        .active(cd_ok), .last(cd - CD_W'(1)), .hit(ticks.sample)
    );

    bitclk_divider #(.W(BD_W)) u_bit (
        .clk(clk), .rst(rst), .restart(restart), .step(ticks.sample),
        .active(1'b1), .last(bdiv), .hit(ticks.baud)
    );

    assign sample_tick = ticks.sample;
    assign baud_tick   = ticks.baud;

    // R1: strobes are quiet in the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sample_tick && !baud_tick));

    // R3: a sample tick needs the prescaler strobe
    assert_presc_gate_R3: assert property (@(posedge clk) disable iff (rst)
        sample_tick |-> pre_strobe);

    // R5: a baud tick always lands on a sample tick
    assert_baud_on_sample_R5: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> sample_tick);

    // R6: a CD below the minimum silences the sample strobe
    assert_cd_off_R6: assert property (@(posedge clk) disable iff (rst)
        (cd < CD_W'(MIN_CD)) |-> !sample_tick);

    // R7: counters restart, so no sample tick right after a configuration write
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !sample_tick);

endmodule

// File: tb/test_bitclk_gen.sv
`timescale 1ns/1ps
module test_bitclk_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        sample_tick, baud_tick;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bitclk_gen i_bitclk_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sample_tick(sample_tick), .baud_tick(baud_tick)
    );

    // {prescale, CD, BDIV}
    localparam int NV = 6;
    localparam logic [24:0] VECS [NV] = '{
        {1'b0, 16'd2, 8'd0},
        {1'b0, 16'd3, 8'd4},
        {1'b0, 16'd7, 8'd2},
        {1'b1, 16'd2, 8'd1},
        {1'b1, 16'd3, 8'd4},
        {1'b0, 16'd5, 8'd9}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Leaves the caller at the falling edge of cycle 0 after the write edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_vec(input logic p, input logic [15:0] cd, input logic [7:0] bd);
        int pm, per, win, fs, fb, sb, ns, bad;
        string rq;
        pm  = p ? 8 : 1;
        rq  = p ? "R3" : "R2";
        per = pm * int'(cd) * (int'(bd) + 1);
        win = 2 * per + 4;
        fs = -1; fb = -1; sb = -1; ns = 0; bad = 0;
        wr(2'd0, {15'd0, p});
        wr(2'd1, cd);
        wr(2'd2, {8'd0, bd});
        for (int t = 0; t < win; t++) begin
            if (sample_tick && fs < 0) fs = t;
            if (baud_tick && !sample_tick) bad++;
            if (sample_tick && fb >= 0 && sb < 0) ns++;
            if (baud_tick) begin
                if (fb < 0) fb = t;
                else if (sb < 0) sb = t;
            end
            @(negedge clk);
        end
        chk(fs == pm * int'(cd) - 1, rq, fs, pm * int'(cd) - 1);
        chk(fb == per - 1, "R4", fb, per - 1);
        chk(sb - fb == per, "R4", sb - fb, per);
        chk(ns == int'(bd) + 1, "R5", ns, int'(bd) + 1);
        chk(bad == 0, "R5", bad, 0);
    endtask

    task automatic quiet(input int cycles, input string req);
        int seen;
        seen = 0;
        for (int t = 0; t < cycles; t++) begin
            if (sample_tick || baud_tick) seen++;
            @(negedge clk);
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int fs, fb, consec, prev;
        repeat (3) @(negedge clk);
        chk(!sample_tick && !baud_tick, "R1", int'(sample_tick) + int'(baud_tick), 0);
        rst = 1'b0;
        quiet(20, "R1");

        for (int i = 0; i < NV; i++)
            run_vec(VECS[i][24], VECS[i][23:8], VECS[i][7:0]);

        // R8: sample strobe one clock wide at the fastest rate
        wr(2'd0, 16'd0); wr(2'd2, 16'd0); wr(2'd1, 16'd2);
        consec = 0; prev = 0;
        for (int t = 0; t < 40; t++) begin
            if (sample_tick && prev != 0) consec++;
            prev = int'(sample_tick);
            @(negedge clk);
        end
        chk(consec == 0, "R8", consec, 0);

        // R6: CD of 1 and of 0 both silence the strobes
        wr(2'd1, 16'd1);
        quiet(60, "R6");
        wr(2'd1, 16'd0);
        quiet(60, "R6");

        // R7: a rewrite mid-period restarts the timing
        wr(2'd1, 16'd10); wr(2'd2, 16'd3);
        fs = -1; fb = -1;
        for (int t = 0; t < 70; t++) begin
            if (t == 15) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd3; end
            if (t == 16) wr_en = 1'b0;
            if (t > 9 && sample_tick && fs < 0) fs = t;
            if (baud_tick && fb < 0) fb = t;
            @(negedge clk);
        end
        chk(fs == 25, "R7", fs, 25);
        chk(fb == 55, "R7", fb, 55);

        // R9: a write to address 3 is ignored and does not restart
        wr(2'd1, 16'd10); wr(2'd2, 16'd3);
        fs = -1; fb = -1;
        for (int t = 0; t < 50; t++) begin
            if (t == 3) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'd0; end
            if (t == 4) wr_en = 1'b0;
            if (sample_tick && fs < 0) fs = t;
            if (baud_tick && fb < 0) fb = t;
            @(negedge clk);
        end
        chk(fs == 9, "R9", fs, 9);
        chk(fb == 39, "R9", fb, 39);

        // R10: largest BDIV
        run_vec(1'b0, 16'd2, 8'd255);

        // R10: largest CD
        wr(2'd0, 16'd0); wr(2'd2, 16'd0); wr(2'd1, 16'd65535);
        fs = -1; fb = -1;
        for (int t = 0; t < 65540; t++) begin
            if (sample_tick && fs < 0) fs = t;
            if (baud_tick && fb < 0) fb = t;
            @(negedge clk);
        end
        chk(fs == 65534, "R10", fs, 65534);
        chk(fb == 65534, "R10", fb, 65534);

        // R1: reset mid-run clears the settings
        wr(2'd1, 16'd2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!sample_tick && !baud_tick, "R1", int'(sample_tick) + int'(baud_tick), 0);
        @(negedge clk);
        rst = 1'b0;
        quiet(30, "R1");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule